// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block keeps the digital state of four digitally controlled potentiometer channels. Each channel owns an 8-bit volatile wiper register. The value in that register picks one of 256 resistor taps, and the block decodes it into a one-hot tap-switch select. Each channel also has four data registers. These are modelled as retained storage that a host can fill, read back and move to or from the wiper.

Two control paths reach the wipers. A single-cycle register-access port takes the place of a serial bus. It performs reads, writes and one-cycle transfers between a channel's data registers and its wiper. A stepper port moves one chosen wiper by one position on each rising edge of a step strobe. The stepper port has a chip select, a direction input and a two-bit channel select.

When reset is released, every wiper is loaded from data register 0 of its channel before any request is taken. A write-protect input freezes the data registers and leaves the wipers free.

Top module: `quad_wiper_bank`

## Requirements
- R1: There are four independent channels. Each channel's 8-bit wiper value appears on `wiper_pos[8c+7:8c]` for channel c, and a change to one channel leaves the other channels unchanged.
- R2: `tap_sel` is one-hot per channel. Bit `256*c + wiper_pos_c` is set, and every other bit of channel c's 256-bit slice is clear.
- R3: While `rst_n` is low and during the first clock cycle after it rises, `ready` is 0 and requests on both ports are ignored. On that first clock edge each wiper takes the value of data register 0 of its channel, and `ready` goes to 1.
- R4: After reset, data register i of channel c holds `DR_BASE + CH_STRIDE*c + i`. With the default parameters this is `0x40 + 16*c + i`.
- R5: A bus request is accepted when `ready` and `bus_req` are both 1. `bus_op` 0 is a read and 1 is a write. `bus_tgt` 1 selects the wiper register of `bus_ch`, and 0 selects data register `bus_dr` of `bus_ch`. Read data appears on `bus_rdata` one cycle later, with a one-cycle `bus_rvalid` pulse.
- R6: `bus_op` 2 copies data register `bus_dr` into the wiper of `bus_ch`. `bus_op` 3 copies the wiper into that data register. Both complete at the accepting clock edge, and `xfer_done` pulses for one cycle on the next cycle.
- R7: On the cycle where `ud_cs` rises, `ud_sel` is captured as the stepping channel. While `ud_cs` is high, each rising edge of `ud_step` moves that wiper by one position: up when `ud_dir` is 1, down when it is 0.
- R8: Stepping saturates at 0 and at 255 and never wraps around.
- R9: If a bus write or a load reaches a wiper in the same cycle as a step edge for that wiper, the bus value is stored and the step is dropped.
- R10: While `wp` is 1, data-register writes and stores leave the data registers unchanged. Wiper writes, loads and stepping still take effect.
- R11: Step edges while `ud_cs` is low have no effect. Changing `ud_sel` while `ud_cs` stays high does not retarget the stepper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register-access request strobe |
| bus_op | input | 2 | 0 read, 1 write, 2 load data->wiper, 3 store wiper->data |
| bus_tgt | input | 1 | For read/write: 1 wiper, 0 data register |
| bus_ch | input | 2 | Target channel |
| bus_dr | input | 2 | Data register index |
| bus_wdata | input | 8 | Write data |
| wp | input | 1 | Write protect for data registers |
| ud_cs | input | 1 | Stepper chip select |
| ud_sel | input | 2 | Stepper channel select, captured on chip-select rise |
| ud_dir | input | 1 | Step direction, 1 up |
| ud_step | input | 1 | Step strobe, acts on rising edges |
| bus_rdata | output | 8 | Read data |
| bus_rvalid | output | 1 | Read data valid pulse |
| xfer_done | output | 1 | Transfer completion pulse |
| ready | output | 1 | Recall finished, requests accepted |
| wiper_pos | output | 32 | Wiper values, channel c at bits 8c+7:8c |
| tap_sel | output | 1024 | One-hot tap selects, 256 bits per channel |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit wipers, four data registers, base 0x40 and stride 16. These defaults put every channel's recalled start value well inside the range, so the data-register pattern can be checked directly after recall. Both saturation ends are reached by first writing a wiper next to 0 or 255 and then stepping past that end. The full 1024-bit tap vector is compared against a one-hot pattern built in the bench after every wiper change, and bus read data passes through a queue-based scoreboard.

// File: rtl/qwb_pkg.sv
// Package: shared encodings for the quad wiper register bank.
// Assumes a two-bit operation field on the register-access port.
package qwb_pkg;

    // Register-access operation codes
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_LOAD  = 2'd2,
        OP_STORE = 2'd3
    } bus_op_e;

    // Target selector for read and write
    localparam logic TGT_DATA  = 1'b0;
    localparam logic TGT_WIPER = 1'b1;

endpackage

// File: rtl/qwb_tap_decode.sv
// Module: qwb_tap_decode
// Turns one wiper value into a one-hot tap-switch select.
// Assumes NUM_TAPS equals 2**POS_W, so every value maps to a tap.
module qwb_tap_decode #(
    parameter int POS_W    = 8,
    parameter int NUM_TAPS = 1 << POS_W
) (
    input  logic [POS_W-1:0]    pos,
    output logic [NUM_TAPS-1:0] tap
);

    // One comparator per tap position
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign tap[t] = (pos == POS_W'(t));
    end

endmodule

// File: rtl/qwb_channel.sv
// Module: qwb_channel
// Holds one wiper register and its data registers, applies recall,
// bus writes and stepping with fixed priority, and decodes the tap.
// Assumes at most one of the write enables is high per cycle from the bus.
module qwb_channel #(
    parameter int POS_W     = 8,
    parameter int NUM_DR    = 4,
    parameter int CH_IDX    = 0,
    parameter int DR_BASE   = 64,
    parameter int CH_STRIDE = 16,
    localparam int DR_W     = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
    localparam int NUM_TAPS = 1 << POS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                recall,
    input  logic                wcr_wr_en,
    input  logic [POS_W-1:0]    wcr_wr_data,
    input  logic                step_en,
    input  logic                step_up,
    input  logic                dr_wr_en,
    input  logic [DR_W-1:0]     dr_idx,
    input  logic [POS_W-1:0]    dr_wr_data,
    output logic [POS_W-1:0]    wcr,
    output logic [POS_W-1:0]    dr_rd_data,
    output logic [POS_W-1:0]    dr0,
    output logic [NUM_TAPS-1:0] tap
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0] dr_q [NUM_DR];
    logic [POS_W-1:0] wcr_d;

    // Next wiper value: recall, then bus, then saturating step
    always_comb begin
        wcr_d = wcr;
        if (recall) begin
            wcr_d = dr_q[0];
        end else if (wcr_wr_en) begin
            wcr_d = wcr_wr_data;
        end else if (step_en) begin
            if (step_up && wcr != POS_MAX) begin
                wcr_d = wcr + 1'b1;
            end else if (!step_up && wcr != '0) begin
                wcr_d = wcr - 1'b1;
            end
        end
    end

    // Wiper register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcr <= '0;
        end else begin
            wcr <= wcr_d;
        end
    end

    // Data registers with a per-channel power-up pattern
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_DR; i++) begin
            if (!rst_n) begin
                dr_q[i] <= POS_W'(DR_BASE + CH_IDX * CH_STRIDE + i);
            end else if (dr_wr_en && dr_idx == DR_W'(i)) begin
                dr_q[i] <= dr_wr_data;
            end
        end
    end

    // Read port and recall source
    assign dr_rd_data = dr_q[dr_idx];
    assign dr0        = dr_q[0];

    qwb_tap_decode #(
        .POS_W    (POS_W),
        .NUM_TAPS (NUM_TAPS)
    ) u_dec (
        .pos (wcr),
        .tap (tap)
    );

endmodule

// File: rtl/qwb_updown.sv
// Module: qwb_updown
// Stepper port: captures the channel on chip-select rise and emits
// a one-hot step enable on each rising step edge while selected.
// Assumes the inputs are already synchronous to clk.
module qwb_updown #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              cs,
    input  logic [CH_W-1:0]   sel,
    input  logic              step,
    output logic [NUM_CH-1:0] step_en
);

    logic            cs_q;
    logic            step_q;
    logic [CH_W-1:0] ch_q;
    logic            cs_rise;
    logic [CH_W-1:0] cur_ch;
    logic            fire;

    // Edge detection and channel choice
    always_comb begin
        cs_rise = cs && !cs_q;
        cur_ch  = cs_rise ? sel : ch_q;
        fire    = ready && cs && step && !step_q;
        step_en = fire ? (NUM_CH'(1) << cur_ch) : '0;
    end

    // History of strobes and the latched channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b0;
            step_q <= 1'b0;
            ch_q   <= '0;
        end else begin
            cs_q   <= cs;
            step_q <= step;
            if (cs_rise) begin
                ch_q <= sel;
            end
        end
    end

endmodule

// File: rtl/qwb_bus_ctrl.sv
// Module: qwb_bus_ctrl
// Decodes one register-access request per cycle into per-channel
// write enables, and registers read data and completion pulses.
// Assumes requests are only acted on when ready is high.
module qwb_bus_ctrl
    import qwb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int POS_W  = 8,
    parameter int NUM_DR = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DR_W  = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ready,
    input  logic                    req,
    input  logic [1:0]              op,
    input  logic                    tgt,
    input  logic [CH_W-1:0]         ch,
    input  logic                    wp,
    input  logic [POS_W-1:0]        wdata,
    input  logic [NUM_CH*POS_W-1:0] wcr_flat,
    input  logic [NUM_CH*POS_W-1:0] dr_rd_flat,
    output logic [NUM_CH-1:0]       wcr_wr_en,
    output logic [POS_W-1:0]        wcr_wr_data,
    output logic [NUM_CH-1:0]       dr_wr_en,
    output logic [POS_W-1:0]        dr_wr_data,
    output logic [POS_W-1:0]        rdata,
    output logic                    rvalid,
    output logic                    done
);

    bus_op_e          op_e;
    logic             acc;
    logic [NUM_CH-1:0] ch_hot;
    logic [POS_W-1:0] sel_wcr;
    logic [POS_W-1:0] sel_dr;
    logic             do_wcr;
    logic             do_dr;

    // Request decode into shared data and one-hot enables
    always_comb begin
        op_e    = bus_op_e'(op);
        acc     = ready && req;
        ch_hot  = NUM_CH'(1) << ch;
        sel_wcr = wcr_flat[ch*POS_W +: POS_W];
        sel_dr  = dr_rd_flat[ch*POS_W +: POS_W];
        do_wcr  = acc && ((op_e == OP_WRITE && tgt == TGT_WIPER) || op_e == OP_LOAD);
        do_dr   = acc && !wp &&
                  ((op_e == OP_WRITE && tgt == TGT_DATA) || op_e == OP_STORE);
        wcr_wr_en   = do_wcr ? ch_hot : '0;
        wcr_wr_data = (op_e == OP_LOAD) ? sel_dr : wdata;
        dr_wr_en    = do_dr ? ch_hot : '0;
        dr_wr_data  = (op_e == OP_STORE) ? sel_wcr : wdata;
    end

    // Registered read data and completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            done   <= 1'b0;
        end else begin
            rvalid <= acc && op_e == OP_READ;
            done   <= acc && (op_e == OP_LOAD || op_e == OP_STORE);
            if (acc && op_e == OP_READ) begin
                rdata <= (tgt == TGT_WIPER) ? sel_wcr : sel_dr;
            end
        end
    end

    // Silence unused-width slack when DR_W is only used by the top
    localparam int UNUSED_DR_W = DR_W;

endmodule

// File: rtl/quad_wiper_bank.sv
// Module: quad_wiper_bank
// Top of the quad wiper register bank: four channels, a register-access
// port, a stepper port and recall of data register 0 after reset.
// Assumes all inputs are synchronous to clk.
module quad_wiper_bank #(
    parameter int NUM_CH    = 4,
    parameter int POS_W     = 8,
    parameter int NUM_DR    = 4,
    parameter int DR_BASE   = 64,
    parameter int CH_STRIDE = 16,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DR_W     = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
    localparam int NUM_TAPS = 1 << POS_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_req,
    input  logic [1:0]                 bus_op,
    input  logic                       bus_tgt,
    input  logic [CH_W-1:0]            bus_ch,
    input  logic [DR_W-1:0]            bus_dr,
    input  logic [POS_W-1:0]           bus_wdata,
    input  logic                       wp,
    input  logic                       ud_cs,
    input  logic [CH_W-1:0]            ud_sel,
    input  logic                       ud_dir,
    input  logic                       ud_step,
    output logic [POS_W-1:0]           bus_rdata,
    output logic                       bus_rvalid,
    output logic                       xfer_done,
    output logic                       ready,
    output logic [NUM_CH*POS_W-1:0]    wiper_pos,
    output logic [NUM_CH*NUM_TAPS-1:0] tap_sel
);

    logic                    recall_pend;
    logic [NUM_CH-1:0]       wcr_hit;
    logic [POS_W-1:0]        wcr_wr_data;
    logic [NUM_CH-1:0]       dr_wr_en;
    logic [POS_W-1:0]        dr_wr_data;
    logic [NUM_CH-1:0]       step_en;
    logic [NUM_CH*POS_W-1:0] dr_rd_flat;
    logic [NUM_CH*POS_W-1:0] dr0_flat;

    // Recall sequencing: one cycle after reset, then ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recall_pend <= 1'b1;
        end else begin
            recall_pend <= 1'b0;
        end
    end

    assign ready = !recall_pend;

    qwb_bus_ctrl #(
        .NUM_CH (NUM_CH),
        .POS_W  (POS_W),
        .NUM_DR (NUM_DR)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready       (ready),
        .req         (bus_req),
        .op          (bus_op),
        .tgt         (bus_tgt),
        .ch          (bus_ch),
        .wp          (wp),
        .wdata       (bus_wdata),
        .wcr_flat    (wiper_pos),
        .dr_rd_flat  (dr_rd_flat),
        .wcr_wr_en   (wcr_hit),
        .wcr_wr_data (wcr_wr_data),
        .dr_wr_en    (dr_wr_en),
        .dr_wr_data  (dr_wr_data),
        .rdata       (bus_rdata),
        .rvalid      (bus_rvalid),
        .done        (xfer_done)
    );

    qwb_updown #(
        .NUM_CH (NUM_CH)
    ) u_ud (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready   (ready),
        .cs      (ud_cs),
        .sel     (ud_sel),
        .step    (ud_step),
        .step_en (step_en)
    );

    // One channel instance per potentiometer
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qwb_channel #(
            .POS_W     (POS_W),
            .NUM_DR    (NUM_DR),
            .CH_IDX    (c),
            .DR_BASE   (DR_BASE),
            .CH_STRIDE (CH_STRIDE)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .recall      (recall_pend),
            .wcr_wr_en   (wcr_hit[c]),
            .wcr_wr_data (wcr_wr_data),
            .step_en     (step_en[c]),
            .step_up     (ud_dir),
            .dr_wr_en    (dr_wr_en[c]),
            .dr_idx      (bus_dr),
            .dr_wr_data  (dr_wr_data),
            .wcr         (wiper_pos[c*POS_W +: POS_W]),
            .dr_rd_data  (dr_rd_flat[c*POS_W +: POS_W]),
            .dr0         (dr0_flat[c*POS_W +: POS_W]),
            .tap         (tap_sel[c*NUM_TAPS +: NUM_TAPS])
        );
    end

endmodule

// File: rtl/qwb_checker.sv
// Module: qwb_checker
// Protocol and state assertions for quad_wiper_bank, attached by bind.
// Assumes the encodings of qwb_pkg.
module qwb_checker
    import qwb_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int POS_W    = 8,
    localparam int NUM_TAPS = 1 << POS_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ready,
    input logic                       bus_req,
    input logic [1:0]                 bus_op,
    input logic                       bus_tgt,
    input logic                       wp,
    input logic                       bus_rvalid,
    input logic                       xfer_done,
    input logic [NUM_CH*POS_W-1:0]    wiper_pos,
    input logic [NUM_CH*NUM_TAPS-1:0] tap_sel,
    input logic [NUM_CH*POS_W-1:0]    dr0_flat,
    input logic [NUM_CH-1:0]          wcr_hit
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0]  prev_pos [NUM_CH];
    logic [NUM_CH-1:0] prev_hit;
    logic              prev_ready;

    // History of wiper values for the step-size checks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_hit   <= '0;
            prev_ready <= 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                prev_pos[c] <= '0;
            end
        end else begin
            prev_hit   <= wcr_hit;
            prev_ready <= ready;
            for (int c = 0; c < NUM_CH; c++) begin
                prev_pos[c] <= wiper_pos[c*POS_W +: POS_W];
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R2: the tap slice is one-hot at the wiper value
        assert_tap_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(tap_sel[c*NUM_TAPS +: NUM_TAPS]) == 1 &&
            tap_sel[c*NUM_TAPS + int'(wiper_pos[c*POS_W +: POS_W])]);

        // R8: without a bus write the wiper moves at most one step, no wrap
        assert_step_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (prev_ready && !prev_hit[c]) |->
            (wiper_pos[c*POS_W +: POS_W] == prev_pos[c] ||
             (prev_pos[c] != POS_MAX && wiper_pos[c*POS_W +: POS_W] == prev_pos[c] + 1'b1) ||
             (prev_pos[c] != '0 && wiper_pos[c*POS_W +: POS_W] == prev_pos[c] - 1'b1)));
    end

    // R3: when ready first rises every wiper equals its data register 0
    assert_recall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> wiper_pos == dr0_flat);

    // R5: an accepted read gives a valid pulse next cycle
    assert_read_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bus_req && bus_op == OP_READ) |=> bus_rvalid);

    // R6: an accepted transfer gives a done pulse next cycle
    assert_xfer_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bus_req && (bus_op == OP_LOAD || bus_op == OP_STORE)) |=> xfer_done);

    // R10: protected data-register writes leave register 0 untouched
    assert_wp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bus_req && wp &&
         ((bus_op == OP_WRITE && bus_tgt == TGT_DATA) || bus_op == OP_STORE))
        |=> $stable(dr0_flat));

endmodule

bind quad_wiper_bank qwb_checker #(
    .NUM_CH (NUM_CH),
    .POS_W  (POS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .bus_req    (bus_req),
    .bus_op     (bus_op),
    .bus_tgt    (bus_tgt),
    .wp         (wp),
    .bus_rvalid (bus_rvalid),
    .xfer_done  (xfer_done),
    .wiper_pos  (wiper_pos),
    .tap_sel    (tap_sel),
    .dr0_flat   (dr0_flat),
    .wcr_hit    (wcr_hit)
);

// File: tb/sim_quad_wiper_bank.sv
// Bench: scoreboard for quad_wiper_bank. Driver tasks keep a reference
// model of the registers and queue expected read data; a monitor pops
// and compares when read data is valid.
module sim_quad_wiper_bank;

    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic [1:0]    bus_op = 2'd0;
    logic          bus_tgt = 1'b0;
    logic [1:0]    bus_ch = 2'd0;
    logic [1:0]    bus_dr = 2'd0;
    logic [7:0]    bus_wdata = 8'd0;
    logic          wp = 1'b0;
    logic          ud_cs = 1'b0;
    logic [1:0]    ud_sel = 2'd0;
    logic          ud_dir = 1'b0;
    logic          ud_step = 1'b0;
    logic [7:0]    bus_rdata;
    logic          bus_rvalid;
    logic          xfer_done;
    logic          ready;
    logic [31:0]   wiper_pos;
    logic [1023:0] tap_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [7:0] wcr_m [4];
    logic [7:0] dr_m  [4][4];
    int         ud_ch_m = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_wiper_bank u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_op     (bus_op),
        .bus_tgt    (bus_tgt),
        .bus_ch     (bus_ch),
        .bus_dr     (bus_dr),
        .bus_wdata  (bus_wdata),
        .wp         (wp),
        .ud_cs      (ud_cs),
        .ud_sel     (ud_sel),
        .ud_dir     (ud_dir),
        .ud_step    (ud_step),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .xfer_done  (xfer_done),
        .ready      (ready),
        .wiper_pos  (wiper_pos),
        .tap_sel    (tap_sel)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected read data when valid appears
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R5 unexpected read: got %h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s read: got %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_cycle(logic [1:0] op, logic tgt, int ch, int dr, logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_op = op; bus_tgt = tgt;
        bus_ch = 2'(ch); bus_dr = 2'(dr); bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic rd(logic tgt, int ch, int dr, string tag);
        exp_q.push_back(tgt ? wcr_m[ch] : dr_m[ch][dr]);
        tag_q.push_back(tag);
        bus_cycle(2'd0, tgt, ch, dr, 8'h00);
    endtask

    task automatic wr(logic tgt, int ch, int dr, logic [7:0] d);
        if (tgt) wcr_m[ch] = d;
        else if (!wp) dr_m[ch][dr] = d;
        bus_cycle(2'd1, tgt, ch, dr, d);
    endtask

    task automatic xfer(bit store, int ch, int dr, string tag);
        if (store) begin
            if (!wp) dr_m[ch][dr] = wcr_m[ch];
        end else begin
            wcr_m[ch] = dr_m[ch][dr];
        end
        bus_cycle(store ? 2'd3 : 2'd2, 1'b0, ch, dr, 8'h00);
        check({tag, " done pulse"}, 32'(xfer_done), 32'd1);
        @(negedge clk);
        check({tag, " done one cycle"}, 32'(xfer_done), 32'd0);
    endtask

    task automatic cs_on(int ch);
        @(negedge clk);
        ud_cs = 1'b1; ud_sel = 2'(ch); ud_ch_m = ch;
    endtask

    task automatic cs_off();
        @(negedge clk);
        ud_cs = 1'b0;
    endtask

    task automatic step(logic dir);
        @(negedge clk);
        ud_dir = dir; ud_step = 1'b1;
        if (ud_cs) begin
            if (dir && wcr_m[ud_ch_m] != 8'hFF) wcr_m[ud_ch_m] = wcr_m[ud_ch_m] + 1;
            if (!dir && wcr_m[ud_ch_m] != 8'h00) wcr_m[ud_ch_m] = wcr_m[ud_ch_m] - 1;
        end
        @(negedge clk);
        ud_step = 1'b0;
    endtask

    task automatic check_pos(string tag);
        for (int c = 0; c < 4; c++) begin
            check(tag, 32'(wiper_pos[c*8 +: 8]), 32'(wcr_m[c]));
        end
    endtask

    task automatic check_taps(string tag);
        logic [1023:0] e;
        e = '0;
        for (int c = 0; c < 4; c++) e[c*256 + int'(wcr_m[c])] = 1'b1;
        n_tests++;
        if (tap_sel !== e) begin
            n_fail++;
            $display("FAIL %s: tap mismatch got %h expected %h", tag, tap_sel, e);
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 4; i++) dr_m[c][i] = 8'(64 + 16*c + i);
            wcr_m[c] = dr_m[c][0];
        end
        repeat (3) @(negedge clk);
        check("R3 ready low in reset", 32'(ready), 32'd0);
        // Release reset with a wiper write that must be ignored
        rst_n = 1'b1;
        bus_req = 1'b1; bus_op = 2'd1; bus_tgt = 1'b1; bus_ch = 2'd0; bus_wdata = 8'hAA;
        ud_cs = 1'b1; ud_step = 1'b1; ud_dir = 1'b1; ud_sel = 2'd1;
        check("R3 ready low in recall cycle", 32'(ready), 32'd0);
        @(negedge clk);
        bus_req = 1'b0; ud_cs = 1'b0; ud_step = 1'b0;
        check("R3 ready after recall", 32'(ready), 32'd1);
        check_pos("R3 recall of data register 0");
        check_taps("R2 taps after recall");

        rd(1'b0, 1, 2, "R4 ch1 dr2");
        rd(1'b0, 3, 3, "R4 ch3 dr3");
        rd(1'b1, 0, 0, "R3 ch0 wiper ignored write");

        wr(1'b1, 2, 0, 8'h10);
        rd(1'b1, 2, 0, "R5 wiper write");
        check_pos("R1 only ch2 changed");
        check_taps("R2 taps after write");
        wr(1'b0, 0, 1, 8'h5A);
        rd(1'b0, 0, 1, "R5 data write");

        xfer(1'b0, 0, 1, "R6 load");
        check_pos("R6 load into wiper");
        xfer(1'b1, 2, 3, "R6 store");
        rd(1'b0, 2, 3, "R6 store data");

        wp = 1'b1;
        wr(1'b0, 1, 0, 8'hEE);
        rd(1'b0, 1, 0, "R10 protected write");
        xfer(1'b1, 1, 2, "R10 protected store");
        rd(1'b0, 1, 2, "R10 protected store data");
        wr(1'b1, 1, 0, 8'h33);
        rd(1'b1, 1, 0, "R10 wiper write under protect");
        wp = 1'b0;

        cs_on(3);
        step(1'b1); step(1'b1); step(1'b1);
        check("R7 three steps up", 32'(wiper_pos[31:24]), 32'h73);
        step(1'b0);
        check("R7 step down", 32'(wiper_pos[31:24]), 32'h72);
        @(negedge clk); ud_sel = 2'd0;
        step(1'b1);
        check_pos("R11 select change while held");
        cs_off();
        step(1'b1);
        check_pos("R11 step with chip select low");

        wr(1'b1, 1, 0, 8'hFE);
        cs_on(1);
        step(1'b1); step(1'b1); step(1'b1);
        check("R8 top saturation", 32'(wiper_pos[15:8]), 32'hFF);
        cs_off();
        wr(1'b1, 0, 0, 8'h01);
        cs_on(0);
        step(1'b0); step(1'b0); step(1'b0);
        check("R8 bottom saturation", 32'(wiper_pos[7:0]), 32'h00);
        check_taps("R2 taps at both ends");
        cs_off();

        cs_on(2);
        @(negedge clk);
        bus_req = 1'b1; bus_op = 2'd1; bus_tgt = 1'b1; bus_ch = 2'd2; bus_wdata = 8'h80;
        ud_dir = 1'b1; ud_step = 1'b1;
        wcr_m[2] = 8'h80;
        @(negedge clk);
        bus_req = 1'b0; ud_step = 1'b0;
        check("R9 bus wins over step", 32'(wiper_pos[23:16]), 32'h80);
        step(1'b1);
        check("R9 stepping after conflict", 32'(wiper_pos[23:16]), 32'h81);
        cs_off();
        check_pos("R1 all channels final");
        check_taps("R2 taps final");

        repeat (3) @(negedge clk);
        check("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule